// File: doc/BRIEF.md
# Single-Port RAM with Enable-Steered Output Hold

This block is a synchronous single-port RAM with a thin layer of glue logic on its control inputs and on its read data. The user drives one clock enable and one write enable. The array writes only when both are high. It is enabled for any cycle in which either one is high. A registered copy of the user clock enable steers a per-bit output cache. When that registered enable is low, the read data seen by the user stays at its last captured value, even when the array output moves underneath it.

Two parameters choose the variant. The write mode sets how the array output and the enable register behave during a write: write-through (0), or plain (non-zero) with no read-out during a write. The read mode sets the read latency to one cycle (bypass) or two cycles (pipelined). In pipelined mode the steering enable is delayed by one more register so that it stays aligned with the extra data stage. All wrapper flops and array output registers clear on a synchronous active-high reset. Memory contents are not cleared.

Top module: `sp_hold_ram`

## Requirements
- R1: While reset is high at a clock edge, the user read data is all zeros after that edge.
- R2: A memory word changes only on an edge where clock enable and write enable are both high. It then takes the write data at the given address.
- R3: The array is enabled when clock enable or write enable is high. With both low, the array output register holds its value.
- R4: In bypass read mode, an edge with clock enable high and write enable low presents the addressed word on the read data one cycle later.
- R5: In write mode 0, the enable register is forced to 0 on any edge where write enable is high, so the read data does not change across that edge.
- R6: In a non-zero write mode, a write (clock enable and write enable high) leaves the array output register unchanged.
- R7: In write mode 0, a write also loads the written data into the array output register (write-through).
- R8: In pipelined read mode, a read at edge t shows the addressed word on the read data after edge t+1, not after edge t.
- R9: On each edge where the steering enable is 1, the cache captures the array output. While the steering enable is 0, the read data shows the cache. In bypass mode, an edge with clock enable low leaves the read data unchanged.
- R10: A synchronous reset in the middle of operation clears the read data, the cache and the enable registers. After it, the memory still returns the words written before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset of all wrapper and output flops |
| ce_i | input | 1 | User clock enable |
| we_i | input | 1 | User write enable |
| addr_i | input | $clog2(DEPTH) | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data after the output hold stage |

## Verification
The bench runs a write-through bypass instance and a plain pipelined instance side by side. It targets the cycles where write enable is high and clock enable is low. A design that wrote to the array on such a cycle would later return 16'hFFFF in place of the stored word. A design that dropped the enable-register clear in write mode 0 would show the write-through data during a write instead of the held value. A plain-mode design that read out during a write would leak new data into the pipeline. A pipelined design that did not delay the steering enable would present the previous stage one cycle early. Random enable patterns with occasional resets are compared cycle by cycle against an expected-value queue, which exposes any lapse in cache capture or hold.

// File: rtl/sp_hold_pkg.sv
package sp_hold_pkg;

    // read latency variants
    localparam int RD_BYPASS = 0;
    localparam int RD_PIPE   = 1;

    // write behaviour variants (any non-zero value is plain)
    localparam int WR_THRU   = 0;
    localparam int WR_PLAIN  = 1;

    // enable tracking flops
    typedef struct packed {
        logic ce_s;   // sampled user clock enable
        logic ce_p;   // one extra stage for pipelined read
    } en_regs_t;

endpackage

// File: rtl/sp_ctl_glue.sv
module sp_ctl_glue
    import sp_hold_pkg::*;
#(
    parameter int WRITE_MODE = WR_THRU,
    parameter int READ_MODE  = RD_BYPASS
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ce_i,
    input  logic we_i,
    output logic arr_we_o,
    output logic arr_en_o,
    output logic sel_o
);

    localparam bit CLR_ON_WE = (WRITE_MODE == WR_THRU);
    localparam bit PIPED     = (READ_MODE == RD_PIPE);

    en_regs_t en_d, en_q;

    // array controls: write needs both, enable needs either
    always_comb begin
        arr_we_o = ce_i & we_i;
        arr_en_o = ce_i | we_i;
    end

    always_comb begin
        en_d = en_q;
        if (CLR_ON_WE && we_i) begin
            en_d.ce_s = 1'b0;
        end else begin
            en_d.ce_s = ce_i;
        end
        en_d.ce_p = en_q.ce_s;
        if (rst_i) begin
            en_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        en_q <= en_d;
    end

    always_comb begin
        sel_o = PIPED ? en_q.ce_p : en_q.ce_s;
    end

endmodule

// File: rtl/sp_bram_core.sv
module sp_bram_core
    import sp_hold_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int DEPTH      = 256,
    parameter int WRITE_MODE = WR_THRU,
    parameter int READ_MODE  = RD_BYPASS,
    localparam int ADDR_W    = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] stage1_o,
    output logic [DATA_W-1:0] dout_o
);

    localparam bit THRU  = (WRITE_MODE == WR_THRU);
    localparam bit PIPED = (READ_MODE == RD_PIPE);

    typedef struct packed {
        logic [DATA_W-1:0] rd;   // first output register
        logic [DATA_W-1:0] pp;   // pipeline register
    } out_regs_t;

    logic [DATA_W-1:0] mem [DEPTH];
    out_regs_t out_d, out_q;

    always_ff @(posedge clk_i) begin
        if (en_i && we_i) begin
            mem[addr_i] <= wdata_i;
        end
    end

    always_comb begin
        out_d    = out_q;
        out_d.pp = out_q.rd;
        if (en_i) begin
            if (we_i) begin
                if (THRU) begin
                    out_d.rd = wdata_i;
                end
            end else begin
                out_d.rd = mem[addr_i];
            end
        end
        if (rst_i) begin
            out_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        out_q <= out_d;
    end

    always_comb begin
        stage1_o = out_q.rd;
        dout_o   = PIPED ? out_q.pp : out_q.rd;
    end

endmodule

// File: rtl/sp_out_cache.sv
module sp_out_cache #(
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sel_i,
    input  logic [DATA_W-1:0] live_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] cache_d, cache_q;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        always_comb begin
            if (rst_i) begin
                cache_d[b] = 1'b0;
            end else if (sel_i) begin
                cache_d[b] = live_i[b];
            end else begin
                cache_d[b] = cache_q[b];
            end
            rdata_o[b] = sel_i ? live_i[b] : cache_q[b];
        end

        always_ff @(posedge clk_i) begin
            cache_q[b] <= cache_d[b];
        end
    end

endmodule

// File: rtl/sp_hold_ram.sv
module sp_hold_ram
    import sp_hold_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int DEPTH      = 256,
    parameter int WRITE_MODE = WR_THRU,
    parameter int READ_MODE  = RD_BYPASS,
    localparam int ADDR_W    = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ce_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic              arr_we;
    logic              arr_en;
    logic              sel;
    logic [DATA_W-1:0] arr_stage1;
    logic [DATA_W-1:0] arr_out;

    sp_ctl_glue #(
        .WRITE_MODE(WRITE_MODE),
        .READ_MODE (READ_MODE)
    ) u_ctl (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .ce_i    (ce_i),
        .we_i    (we_i),
        .arr_we_o(arr_we),
        .arr_en_o(arr_en),
        .sel_o   (sel)
    );

    sp_bram_core #(
        .DATA_W    (DATA_W),
        .DEPTH     (DEPTH),
        .WRITE_MODE(WRITE_MODE),
        .READ_MODE (READ_MODE)
    ) u_core (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (arr_en),
        .we_i    (arr_we),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .stage1_o(arr_stage1),
        .dout_o  (arr_out)
    );

    sp_out_cache #(
        .DATA_W(DATA_W)
    ) u_cache (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .sel_i  (sel),
        .live_i (arr_out),
        .rdata_o(rdata_o)
    );

endmodule

// File: rtl/sp_hold_ram_chk.sv
module sp_hold_ram_chk
    import sp_hold_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int WRITE_MODE = WR_THRU,
    parameter int READ_MODE  = RD_BYPASS
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              ce_i,
    input logic              we_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic [DATA_W-1:0] arr_stage1
);

    localparam bit THRU  = (WRITE_MODE == WR_THRU);
    localparam bit PIPED = (READ_MODE == RD_PIPE);

    // R1
    reset_zero_chk: assert property (@(posedge clk_i)
        rst_i |=> (rdata_o == '0));

    // R3
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!ce_i && !we_i) |=> $stable(arr_stage1));

    // R4
    bypass_read_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!PIPED && ce_i && !we_i) |=> (rdata_o == arr_stage1));

    // R5
    thru_we_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (THRU && !PIPED && we_i) |=> $stable(rdata_o));

    // R6
    plain_no_readout_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!THRU && ce_i && we_i) |=> $stable(arr_stage1));

    // R7
    thru_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (THRU && ce_i && we_i) |=> (arr_stage1 == $past(wdata_i)));

    // R8
    pipe_latency_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (PIPED && ce_i && !we_i) ##1 1'b1 |=> (rdata_o == $past(arr_stage1)));

    // R9
    bypass_ce_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!PIPED && !ce_i) |=> $stable(rdata_o));

endmodule

bind sp_hold_ram sp_hold_ram_chk #(
    .DATA_W    (DATA_W),
    .WRITE_MODE(WRITE_MODE),
    .READ_MODE (READ_MODE)
) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .ce_i      (ce_i),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .arr_stage1(arr_stage1)
);

// File: tb/tb_sp_hold_ram.sv
module tb_sp_hold_ram;

    localparam int W  = 16;
    localparam int D  = 256;
    localparam int AW = $clog2(D);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce  = 1'b0;
    logic          we  = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  rdata0;
    logic [W-1:0]  rdata1;

    int checks = 0;
    int bad    = 0;

    always #10 clk = ~clk;

    // write-through, bypass
    sp_hold_ram #(.DATA_W(W), .DEPTH(D), .WRITE_MODE(0), .READ_MODE(0)) dut (
        .clk_i(clk), .rst_i(rst), .ce_i(ce), .we_i(we),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata0));

    // plain, pipelined
    sp_hold_ram #(.DATA_W(W), .DEPTH(D), .WRITE_MODE(1), .READ_MODE(1)) dut_p (
        .clk_i(clk), .rst_i(rst), .ce_i(ce), .we_i(we),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata1));

    // expected-value model, index 0 = dut, 1 = dut_p
    logic [W-1:0] m_mem [2][D];
    logic [W-1:0] m_rd [2];
    logic [W-1:0] m_pp [2];
    logic [W-1:0] m_ca [2];
    logic         m_cs [2];
    logic         m_cp [2];

    typedef struct {
        int          k;
        logic [W-1:0] v;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    task automatic mstep(input int k, input logic r, input logic c, input logic w,
                         input logic [AW-1:0] a, input logic [W-1:0] d,
                         output logic [W-1:0] exp_v);
        bit piped = (k == 1);
        bit thru  = (k == 0);
        logic         sel_o;
        logic [W-1:0] out_o;
        logic [W-1:0] rd_o;
        logic         cs_o;
        sel_o = piped ? m_cp[k] : m_cs[k];
        out_o = piped ? m_pp[k] : m_rd[k];
        rd_o  = m_rd[k];
        cs_o  = m_cs[k];
        if (r) begin
            m_rd[k] = '0; m_pp[k] = '0; m_ca[k] = '0; m_cs[k] = 1'b0; m_cp[k] = 1'b0;
        end else begin
            if (sel_o) m_ca[k] = out_o;
            m_pp[k] = rd_o;
            if (c || w) begin
                if (c && w) begin
                    if (thru) m_rd[k] = d;
                end else begin
                    m_rd[k] = m_mem[k][a];
                end
            end
            m_cp[k] = cs_o;
            m_cs[k] = (thru && w) ? 1'b0 : c;
        end
        if (c && w) m_mem[k][a] = d;
        if (piped) exp_v = m_cp[k] ? m_pp[k] : m_ca[k];
        else       exp_v = m_cs[k] ? m_rd[k] : m_ca[k];
    endtask

    // driver: applies one cycle, then queues both expected outputs
    task automatic drive(input logic r, input logic c, input logic w,
                         input logic [AW-1:0] a, input logic [W-1:0] d, input string tag);
        logic [W-1:0] e;
        @(negedge clk);
        rst = r; ce = c; we = w; addr = a; wdata = d;
        @(posedge clk);
        #1;
        for (int k = 0; k < 2; k++) begin
            sb_item_t it;
            mstep(k, r, c, w, a, d, e);
            it.k = k; it.v = e; it.tag = tag;
            sb_q.push_back(it);
        end
    endtask

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp_v, input string tag);
        checks++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // monitor: pops queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            sb_item_t it;
            logic [W-1:0] act;
            it  = sb_q.pop_front();
            act = (it.k == 0) ? rdata0 : rdata1;
            checks++;
            if (act !== it.v) begin
                bad++;
                $display("FAIL %s inst=%0d actual=%h expected=%h", it.tag, it.k, act, it.v);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            m_rd[k] = '0; m_pp[k] = '0; m_ca[k] = '0; m_cs[k] = 1'b0; m_cp[k] = 1'b0;
        end
        // R1: reset state
        drive(1, 0, 0, 0, 0, "R1 reset");
        drive(1, 0, 0, 0, 0, "R1 reset");
        chk(rdata0, '0, "R1 reset bypass");
        chk(rdata1, '0, "R1 reset pipelined");
        // fill the low addresses so later reads are defined
        for (int i = 0; i < 16; i++) drive(0, 1, 1, AW'(i), W'(16'h0100 + i), "R2 fill");
        drive(0, 0, 0, 0, 0, "R9 idle");
        drive(0, 0, 0, 0, 0, "R9 idle");
        drive(1, 0, 0, 0, 0, "R10 reset");
        chk(rdata0, '0, "R10 reset clears bypass");
        chk(rdata1, '0, "R10 reset clears pipelined");

        // R2 write then R4 read
        drive(0, 1, 1, 3, 16'hA5A5, "R2 write");
        chk(rdata0, '0, "R5 write hides output");
        drive(0, 1, 0, 3, 0, "R4 read");
        chk(rdata0, 16'hA5A5, "R4 bypass read");
        chk(rdata1, '0, "R8 pipelined not yet");
        drive(0, 0, 0, 7, 0, "R9 hold");
        chk(rdata0, 16'hA5A5, "R9 hold with ce low");
        chk(rdata1, 16'hA5A5, "R8 pipelined after two");

        // second write: plain mode does no read-out
        drive(0, 1, 1, 3, 16'h1234, "R6 write");
        chk(rdata0, 16'hA5A5, "R5 cache held during write");
        drive(0, 0, 0, 3, 0, "R6 idle");
        chk(rdata1, 16'hA5A5, "R6 plain write no readout");
        chk(rdata0, 16'hA5A5, "R9 hold after write");

        // R3: write enable without clock enable must not write
        drive(0, 0, 1, 3, 16'hFFFF, "R3 we only");
        chk(rdata0, 16'hA5A5, "R3 we only holds output");
        drive(0, 1, 0, 3, 0, "R7 read back");
        chk(rdata0, 16'h1234, "R7 R3 stored word");
        drive(0, 0, 0, 0, 0, "R8 idle");
        chk(rdata1, 16'h1234, "R3 pipelined stored word");

        // R10: mid-run reset keeps memory
        drive(1, 1, 0, 5, 0, "R10 reset");
        chk(rdata0, '0, "R10 mid reset bypass");
        chk(rdata1, '0, "R10 mid reset pipelined");
        drive(0, 1, 0, 5, 0, "R10 read after reset");
        chk(rdata0, 16'h0105, "R10 memory kept");
        drive(0, 0, 0, 0, 0, "R10 idle");
        chk(rdata1, 16'h0105, "R10 memory kept pipelined");

        // random enable patterns against the model
        for (int n = 0; n < 3000; n++) begin
            logic r, c, w;
            r = ($urandom_range(0, 199) == 0);
            c = $urandom_range(0, 1);
            w = ($urandom_range(0, 2) == 0);
            drive(r, c, w, AW'($urandom_range(0, 15)), W'($urandom), "R4 R9 random");
        end
        drive(0, 0, 0, 0, 0, "R9 drain");
        @(negedge clk);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule